// File: doc/BRIEF.md
# Exp-Golomb syntax element encoder

This block turns one syntax element value into an Exp-Golomb codeword of the kind used in video stream headers. It takes a 16-bit value and a flag that selects the unsigned or the signed form. The signed form folds the value onto the unsigned range, and both forms then share one encoding path. The output is a right-justified code word with its bit length. A separate bit packer consumes that pair, so this block does no packing and no byte output.

Input and output each use a valid/ready handshake. An accepted input produces a registered code/length pair on the next clock. That pair stays valid until the consumer takes it. A new input can be accepted in the same cycle as the previous result is handed off, so one value per cycle flows through. The prefix length comes from a leading-one detector on the value plus one. Values whose code would not fit the 16-bit range are saturated to the longest code.

Top module: `expg_encoder`

## Requirements
- R1: In the unsigned form (`in_signed`=0), an input value v produces `out_code` = v+1, zero-extended to 32 bits. It also produces `out_len` = 2k+1, where k is the bit index of the highest set bit of v+1.
- R2: In the signed form (`in_signed`=1), `in_value` is read as two's complement and mapped before the R1 encoding: zero gives 0, a positive v gives 2v−1 and a negative v gives 2·|v|.
- R3: Any mapped value above 0xFFFE is saturated to 0xFFFE. This covers unsigned 0xFFFF and signed −32768 (0x8000). Both then give `out_code`=0x0000FFFF and `out_len`=31.
- R4: An input accepted at a clock edge (`in_valid` and `in_ready` high) appears on `out_code`/`out_len` with `out_valid` high right after that same edge.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_code` and `out_len` stay unchanged and `in_ready` is low. Otherwise `in_ready` is high.
- R6: After reset, `out_valid` is 0, `out_code` is 0, `out_len` is 0 and `in_ready` is 1.
- R7: Read MSB first, every valid code word is k zeros followed by the binary of v+1. The bit at index k=(`out_len`−1)/2 is the highest bit set in `out_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Block can take an input this cycle |
| in_value | input | 16 | Syntax element value (two's complement when signed) |
| in_signed | input | 1 | 1 selects the signed form, 0 the unsigned form |
| out_valid | output | 1 | Code/length pair present |
| out_ready | input | 1 | Consumer takes the pair this cycle |
| out_code | output | 32 | Right-justified code word |
| out_len | output | 6 | Number of code bits, 1 to 31 |

## Verification
Two things can fall in the same clock edge: handing off the held result and accepting the next input. The bench provokes this with three inputs offered on consecutive cycles while `out_ready` stays high. It requires each code to appear exactly one cycle after its input and `in_ready` to stay high throughout. A second case stalls the output with `out_ready` low and an input waiting. It then releases the stall. The bench checks that the held pair did not change during the stall and that the waiting input shows up on the cycle after the release.

// File: rtl/expg_encoder.sv
module expg_encoder #(
  parameter int VW = 16,
  parameter int CW = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_value,
  input  logic          in_signed,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_code,
  output logic [LW-1:0] out_len
);
  localparam int KW = $clog2(VW);
  localparam logic [VW:0] LIMIT = {1'b0, {(VW-1){1'b1}}, 1'b0};

  logic [VW:0]   mapped;
  logic [VW:0]   smag;
  logic [VW-1:0] folded;
  logic [VW-1:0] code_n;
  logic [KW-1:0] msb_k;
  logic          take;

  assign take     = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  always_comb begin
    smag = in_value[VW-1] ? (~{in_value[VW-1], in_value} + 1'b1)
                          : {in_value[VW-1], in_value};
    if (!in_signed)
      mapped = {1'b0, in_value};
    else if (in_value == '0)
      mapped = '0;
    else if (in_value[VW-1])
      mapped = {smag[VW-1:0], 1'b0};
    else
      mapped = {smag[VW-1:0], 1'b0} - 1'b1;
  end

  assign folded = (mapped > LIMIT) ? LIMIT[VW-1:0] : mapped[VW-1:0];
  assign code_n = folded + 1'b1;

  always_comb begin
    msb_k = '0;
    for (int i = 0; i < VW; i++)
      if (code_n[i]) msb_k = KW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_len   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_code  <= CW'(code_n);
      out_len   <= LW'({msb_k, 1'b1});
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_len_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len[0] && out_len <= LW'(2*VW-1)));

  p_top_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_code >> out_len[LW-1:1]) == CW'(1)));

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_len)));

  p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_signed && in_value == '1) |=> (out_code == CW'({VW{1'b1}})));
endmodule

// File: tb/expg_encoder_bench.sv
module expg_encoder_bench;
  localparam int CLK_NS = 10;
  localparam int NTAB = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_value = '0;
  logic        in_signed = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_code;
  logic [5:0]  out_len;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_NS/2) clk = ~clk;

  expg_encoder u_expg_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_signed(in_signed), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_len(out_len)
  );

  // {signed, value, expected code, expected length}
  localparam logic [54:0] TAB [NTAB] = '{
    {1'b0, 16'd0,     32'd1,     6'd1},
    {1'b0, 16'd1,     32'd2,     6'd3},
    {1'b0, 16'd2,     32'd3,     6'd3},
    {1'b0, 16'd3,     32'd4,     6'd5},
    {1'b0, 16'd6,     32'd7,     6'd5},
    {1'b0, 16'd7,     32'd8,     6'd7},
    {1'b0, 16'd8,     32'd9,     6'd7},
    {1'b0, 16'd14,    32'd15,    6'd7},
    {1'b0, 16'd15,    32'd16,    6'd9},
    {1'b0, 16'd254,   32'd255,   6'd15},
    {1'b0, 16'd255,   32'd256,   6'd17},
    {1'b0, 16'd32766, 32'd32767, 6'd29},
    {1'b0, 16'd32767, 32'd32768, 6'd31},
    {1'b0, 16'hFFFE,  32'd65535, 6'd31},
    {1'b0, 16'hFFFF,  32'd65535, 6'd31},
    {1'b1, 16'd0,     32'd1,     6'd1},
    {1'b1, 16'd1,     32'd2,     6'd3},
    {1'b1, 16'hFFFF,  32'd3,     6'd3},
    {1'b1, 16'd2,     32'd4,     6'd5},
    {1'b1, 16'hFFFE,  32'd5,     6'd5},
    {1'b1, 16'd32767, 32'd65534, 6'd31},
    {1'b1, 16'h8001,  32'd65535, 6'd31},
    {1'b1, 16'h8000,  32'd65535, 6'd31}
  };

  task automatic chk(input string req, input logic [31:0] gc, input logic [5:0] gl,
                     input logic gv, input logic [31:0] ec, input logic [5:0] el,
                     input logic ev);
    nvec++;
    if (gc !== ec || gl !== el || gv !== ev) begin
      nbad++;
      $display("FAIL %s: code=%0d len=%0d valid=%0b expected code=%0d len=%0d valid=%0b",
               req, gc, gl, gv, ec, el, ev);
    end
  endtask

  task automatic model(input logic sg, input logic [15:0] v,
                       output logic [31:0] c, output logic [5:0] l);
    int m;
    int t;
    int k;
    if (sg) begin
      m = int'($signed(v));
      m = (m > 0) ? 2*m - 1 : -2*m;
    end else m = int'(v);
    if (m > 65534) m = 65534;
    c = 32'(m + 1);
    t = m + 1;
    k = 0;
    while (t > 1) begin t = t >> 1; k++; end
    l = 6'(2*k + 1);
  endtask

  task automatic one(input string req, input logic sg, input logic [15:0] v,
                     input logic [31:0] ec, input logic [5:0] el);
    @(negedge clk);
    in_signed = sg; in_value = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, out_code, out_len, out_valid, ec, el, 1'b1);
  endtask

  initial begin
    logic [31:0] ec;
    logic [5:0]  el;
    logic [31:0] hc;
    logic [5:0]  hl;

    #(CLK_NS*3);
    chk("R6 reset outputs", out_code, out_len, out_valid, 32'd0, 6'd0, 1'b0);
    chk("R6 reset in_ready", 32'd0, 6'd0, in_ready, 32'd0, 6'd0, 1'b1);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NTAB; i++)
      one(TAB[i][54] ? "R2/R3 table" : "R1/R3 table", TAB[i][54], TAB[i][53:38],
          TAB[i][37:6], TAB[i][5:0]);

    for (int v = 0; v <= 20; v++) begin
      model(1'b0, 16'(v), ec, el);
      one("R1 small unsigned", 1'b0, 16'(v), ec, el);
    end
    for (int n = 1; n <= 16; n++) begin
      model(1'b0, 16'((1 << n) - 1), ec, el);
      one("R7 boundary 2^n-1", 1'b0, 16'((1 << n) - 1), ec, el);
      if (n < 16) begin
        model(1'b0, 16'(1 << n), ec, el);
        one("R7 boundary 2^n", 1'b0, 16'(1 << n), ec, el);
      end
    end
    for (int s = -10; s <= 10; s++) begin
      model(1'b1, 16'(s), ec, el);
      one("R2 signed sweep", 1'b1, 16'(s), ec, el);
    end

    @(negedge clk);
    chk("R4 idle after handoff", 32'd0, 6'd0, out_valid, 32'd0, 6'd0, 1'b0);

    // back-to-back: handoff and accept on the same edge
    in_signed = 1'b0; in_value = 16'd5; in_valid = 1'b1;
    @(negedge clk);
    chk("R4 stream first", out_code, out_len, out_valid, 32'd6, 6'd5, 1'b1);
    chk("R5 stream ready", 32'd0, 6'd0, in_ready, 32'd0, 6'd0, 1'b1);
    in_value = 16'd30;
    @(negedge clk);
    chk("R4 stream second", out_code, out_len, out_valid, 32'd31, 6'd9, 1'b1);
    in_signed = 1'b1; in_value = 16'hFFFD;
    @(negedge clk);
    chk("R4 stream third", out_code, out_len, out_valid, 32'd7, 6'd5, 1'b1);
    in_valid = 1'b0;

    // stall with a waiting input
    @(negedge clk);
    out_ready = 1'b0;
    in_signed = 1'b0; in_value = 16'd100; in_valid = 1'b1;
    @(negedge clk);
    hc = out_code; hl = out_len;
    chk("R4 stalled pair", hc, hl, out_valid, 32'd101, 6'd13, 1'b1);
    in_value = 16'd1000;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R5 held under stall", out_code, out_len, out_valid, 32'd101, 6'd13, 1'b1);
      chk("R5 in_ready low", 32'd0, 6'd0, in_ready, 32'd0, 6'd0, 1'b0);
    end
    out_ready = 1'b1;
    #1;
    chk("R5 in_ready on release", 32'd0, 6'd0, in_ready, 32'd0, 6'd0, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 waiting input after release", out_code, out_len, out_valid, 32'd1001, 6'd19, 1'b1);
    @(negedge clk);
    chk("R5 drained", 32'd0, 6'd0, out_valid, 32'd0, 6'd0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(CLK_NS*20000);
    nvec++; nbad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule